// File: doc/BRIEF.md
# Two-Lane Sample Word Serializer

This block takes a 16-bit conversion result and shifts it out over two one-bit lanes, two bits per slot, across eight slots. Each slot carries one bit pair. The odd bit of the pair goes on one lane and the even bit goes on the other. The most significant pair leaves first. A word-start marker flags the first slot of every word, so the receiver can frame the stream without a separate count.

Timing is taken from `clk_i`, which runs at twice the master-clock rate. The block divides it down and drives the master clock on `mclk_o`. In single-edge mode a slot lasts one master period, and the lanes change only where `mclk_o` rises. In double-edge mode a slot lasts half a master period, so the lanes change on both master edges and a word takes four master periods.

A word may be loaded at any time. It waits in a holding register until the word on the lanes has finished. The edge mode is sampled at the start of each word and applies to that whole word.

Top module: `pair_serializer`

## Requirements
- R1: Slot k of a word (k = 0..7) carries bits 15-2k and 14-2k of the loaded word, so the order is (15,14), (13,12) and so on down to (1,0).
- R2: `lane_odd_o` carries the odd-numbered bit of each pair and `lane_even_o` carries the even-numbered bit.
- R3: In single-edge mode (`mode_i` = 0) each slot lasts two `clk_i` cycles. A slot starts at the edge where `mclk_o` rises, and the lanes do not change while `mclk_o` is low.
- R4: In double-edge mode (`mode_i` = 1) each slot lasts one `clk_i` cycle, so a word occupies eight `clk_i` cycles, which is four master periods.
- R5: `mclk_o` is low during reset and toggles on every `clk_i` edge after reset.
- R6: A word loaded while another word is being sent is held until that word's eighth slot ends. When both words are in the same mode, or the new word is double-edge, it starts in the very next slot, with no idle gap.
- R7: A second load that arrives before a held word has started replaces the held word, and the earlier word is never sent.
- R8: `word_start_o` is high during the slot that carries bits 15 and 14, and low in every other slot.
- R9: During reset and whenever no word is being sent, both lanes and `word_start_o` are 0.
- R10: The mode applied to a word is the value of `mode_i` when that word starts. Changing `mode_i` in the middle of a word does not alter that word's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock at twice the master-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that captures `word_i` into the holding register |
| word_i | input | 16 | Parallel conversion result |
| mode_i | input | 1 | 0 = single-edge, 1 = double-edge |
| lane_odd_o | output | 1 | Odd bit of the current pair |
| lane_even_o | output | 1 | Even bit of the current pair |
| word_start_o | output | 1 | High during the first slot of a word |
| mclk_o | output | 1 | Master clock derived from `clk_i` |

## Verification
Each fault in the internal state has a visible symptom at the ports:

- **Slot pointer off by one step:** the pairs come out rotated. The marker then lines up with the wrong bits, which shows in the first slot of the next word.
- **Phase register out of step:** in single-edge mode the lanes change while `mclk_o` is low. This shows within one master period of the word starting.
- **Holding register that drops or keeps a stale word:** the next word is missing, duplicated, or separated from the previous word by idle slots. This is caught at the boundary where it should have started.

The scoreboard compares every slot sample against the queued word and mode. It also checks idle gaps for quiet lanes.

// File: rtl/pser_pkg.sv
package pser_pkg;
  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/pser_phase.sv
module pser_phase
  import pser_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  edge_mode_e mode_run_i,
  input  edge_mode_e mode_new_i,
  output logic       phase_o,
  output logic       run_tick_o,
  output logic       start_ok_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  // single-edge slots advance only on the edge that raises the master clock
  assign run_tick_o = (mode_run_i == EDGE_DOUBLE) || !phase_q;
  assign start_ok_o = (mode_new_i == EDGE_DOUBLE) || !phase_q;
  assign phase_o    = phase_q;

  AST_PHASE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_q != $past(phase_q))); // R5
endmodule

// File: rtl/pser_hold.sv
module pser_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic              pend_v_o,
  output logic [WORD_W-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o <= 1'b0;
      pend_o   <= '0;
    end else if (load_i) begin
      // a newer load always wins over a held word
      pend_v_o <= 1'b1;
      pend_o   <= word_i;
    end else if (take_i) begin
      pend_v_o <= 1'b0;
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v_o && !load_i && !take_i) |=> (pend_v_o && $stable(pend_o))); // R6
  AST_LOAD_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pend_v_o && pend_o == $past(word_i))); // R7
endmodule

// File: rtl/pser_seq.sv
module pser_seq
  import pser_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SLOTS  = WORD_W / 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_tick_i,
  input  logic              start_ok_i,
  input  logic              pend_v_i,
  input  logic [WORD_W-1:0] pend_i,
  input  edge_mode_e        mode_new_i,
  output logic              take_o,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WORD_W-1:0] word_o,
  output edge_mode_e        mode_o
);
  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(SLOTS - 1);

  logic last_slot, boundary;

  assign last_slot = (slot_o == LastSlot);
  assign boundary  = !active_o || (run_tick_i && last_slot);
  assign take_o    = boundary && pend_v_i && start_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      slot_o   <= '0;
      word_o   <= '0;
      mode_o   <= EDGE_SINGLE;
    end else if (take_o) begin
      active_o <= 1'b1;
      slot_o   <= '0;
      word_o   <= pend_i;
      mode_o   <= mode_new_i;
    end else if (active_o && run_tick_i) begin
      if (last_slot) begin
        active_o <= 1'b0;
        slot_o   <= '0;
      end else begin
        slot_o   <= slot_o + 1'b1;
      end
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && run_tick_i && !last_slot) |=> (slot_o == SLOT_W'($past(slot_o) + 1'b1))); // R1
  AST_SLOT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !run_tick_i) |=> $stable(slot_o)); // R3
  AST_WORD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !(run_tick_i && last_slot)) |=> $stable(word_o)); // R6
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !(run_tick_i && last_slot)) |=> $stable(mode_o)); // R10
  AST_IDLE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (slot_o == '0)); // R9
endmodule

// File: rtl/pser_lanes.sv
module pser_lanes #(
  parameter int WORD_W = 16,
  localparam int SLOTS  = WORD_W / 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              active_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              lane_odd_o,
  output logic              lane_even_o,
  output logic              mark_o
);
  logic [1:0] pair_tab [SLOTS];

  // slot k holds the pair k steps below the top
  for (genvar k = 0; k < SLOTS; k++) begin : g_pair
    assign pair_tab[k] = word_i[WORD_W-1-2*k -: 2];
  end

  logic [1:0] cur_pair;
  assign cur_pair    = pair_tab[slot_i];
  assign lane_odd_o  = active_i & cur_pair[1];
  assign lane_even_o = active_i & cur_pair[0];
  assign mark_o      = active_i && (slot_i == '0);

  always_comb begin
    AST_IDLE_QUIET: assert (active_i || !(lane_odd_o || lane_even_o || mark_o)); // R9
  end
endmodule

// File: rtl/pair_serializer.sv
module pair_serializer
  import pser_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SLOTS  = WORD_W / 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              mode_i,
  output logic              lane_odd_o,
  output logic              lane_even_o,
  output logic              word_start_o,
  output logic              mclk_o
);
  edge_mode_e        mode_new, mode_run;
  logic              run_tick, start_ok, take;
  logic              pend_v, active;
  logic [WORD_W-1:0] pend_word, cur_word;
  logic [SLOT_W-1:0] slot;

  assign mode_new = edge_mode_e'(mode_i);

  pser_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_run_i (mode_run),
    .mode_new_i (mode_new),
    .phase_o    (mclk_o),
    .run_tick_o (run_tick),
    .start_ok_o (start_ok)
  );

  pser_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .word_i   (word_i),
    .take_i   (take),
    .pend_v_o (pend_v),
    .pend_o   (pend_word)
  );

  pser_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_tick_i (run_tick),
    .start_ok_i (start_ok),
    .pend_v_i   (pend_v),
    .pend_i     (pend_word),
    .mode_new_i (mode_new),
    .take_o     (take),
    .active_o   (active),
    .slot_o     (slot),
    .word_o     (cur_word),
    .mode_o     (mode_run)
  );

  pser_lanes #(.WORD_W(WORD_W)) u_lanes (
    .active_i    (active),
    .slot_i      (slot),
    .word_i      (cur_word),
    .lane_odd_o  (lane_odd_o),
    .lane_even_o (lane_even_o),
    .mark_o      (word_start_o)
  );

  AST_MARK_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_run == EDGE_SINGLE && $rose(word_start_o)) |-> mclk_o); // R8
  AST_SINGLE_LOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && mode_run == EDGE_SINGLE && !mclk_o) |-> $stable({lane_odd_o, lane_even_o})); // R3
  AST_DOUBLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && mode_run == EDGE_DOUBLE && slot != SLOT_W'(SLOTS - 1)) |=> (active && slot != $past(slot))); // R4
endmodule

// File: tb/pair_serializer_test.sv
`timescale 1ns/1ps
module pair_serializer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        mode_i = 1'b0;
  logic        lane_odd_o, lane_even_o, word_start_o, mclk_o;

  pair_serializer uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .word_i       (word_i),
    .mode_i       (mode_i),
    .lane_odd_o   (lane_odd_o),
    .lane_even_o  (lane_even_o),
    .word_start_o (word_start_o),
    .mclk_o       (mclk_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] w;
    logic        dbl;
    logic        direct;
    int          req;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic dbl, input logic direct,
                      input bit push, input int req);
    item_t it;
    @(negedge clk);
    load_i = 1'b1;
    word_i = w;
    mode_i = dbl;
    if (push) begin
      it.w = w; it.dbl = dbl; it.direct = direct; it.req = req;
      q.push_back(it);
    end
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_mark();
    @(negedge clk);
    while (!word_start_o) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int gap;
    item_t e;
    wait (rst_ni == 1'b1);
    @(negedge clk);
    forever begin
      gap = 0;
      while (!word_start_o) begin
        chk("R9", {30'd0, lane_odd_o, lane_even_o}, 32'd0);
        gap++;
        @(negedge clk);
      end
      if (q.size() == 0) begin
        chk("R7", 32'd1, 32'd0); // word appeared with nothing expected
        e.w = '0; e.dbl = 1'b0; e.direct = 1'b0; e.req = 1;
      end else begin
        e = q.pop_front();
      end
      if (e.direct) chk("R6", gap, 32'd0);
      for (int s = 0; s < 8; s++) begin
        for (int c = 0; c < (e.dbl ? 1 : 2); c++) begin
          // R1 order, R4 one-cycle slots, R7/R10 per-item tags
          chk($sformatf("R%0d", e.req), {30'd0, lane_odd_o, lane_even_o},
              {30'd0, e.w[15-2*s], e.w[14-2*s]});
          chk("R2", {31'd0, lane_odd_o}, {31'd0, e.w[15-2*s]});
          chk("R8", {31'd0, word_start_o}, {31'd0, s == 0});
          if (!e.dbl) chk("R3", {31'd0, mclk_o}, {31'd0, c == 0});
          @(negedge clk);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic prev;
    repeat (3) @(negedge clk);
    chk("R9", {29'd0, lane_odd_o, lane_even_o, word_start_o}, 32'd0);
    chk("R5", {31'd0, mclk_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    prev = mclk_o;
    @(negedge clk);
    chk("R5", {31'd0, mclk_o}, {31'd0, ~prev});

    // single-edge word, then a mid-word load in the same mode
    send(16'hA5C3, 1'b0, 1'b0, 1'b1, 1);
    wait_mark();
    repeat (3) @(negedge clk);
    send(16'h1234, 1'b0, 1'b1, 1'b1, 1);
    wait_mark();
    repeat (2) @(negedge clk);
    // R7: first load overwritten; R10: mode_i flips to double mid-word
    send(16'hFFFF, 1'b1, 1'b0, 1'b0, 7);
    send(16'h8001, 1'b1, 1'b1, 1'b1, 10);
    wait_mark();
    send(16'h6BD2, 1'b1, 1'b1, 1'b1, 4);
    wait_mark();
    repeat (20) @(negedge clk);
    // double-edge word from idle
    send(16'h0001, 1'b1, 1'b0, 1'b1, 4);
    wait_mark();
    repeat (20) @(negedge clk);
    send(16'hFFFE, 1'b0, 1'b0, 1'b1, 1);
    wait_mark();
    repeat (3) @(negedge clk);
    send(16'h5555, 1'b0, 1'b1, 1'b1, 1);
    wait_mark();
    repeat (3) @(negedge clk);
    send(16'hAAAA, 1'b0, 1'b1, 1'b1, 1);
    while (q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R9", {29'd0, lane_odd_o, lane_even_o, word_start_o}, 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule